// File: doc/BRIEF.md
# Serial Frame Receiver with Odd-Parity Check

This block listens to a one-bit serial line, one bit per clock, for a five-bit frame. A frame is made of two start bits (both '1'), two payload bits sent most significant first, and one parity bit chosen so that the five bits together hold an odd number of ones. The receiver drops a lone '1' that is not followed by a second '1' as line noise. It stores the two payload bits in an output register. In the parity-bit cycle it raises a one-cycle result flag when the parity is odd.

Six one-hot states control the block. `ST_IDLE` waits for a first start bit. On '1' it takes transition *arm* to `ST_START2`; on '0' it takes *idle-hold* and stays. `ST_START2` checks the second start bit. On '1' it takes *accept* to `ST_PAYHI`; on '0' it takes *reject* back to `ST_IDLE`. `ST_PAYHI` stores the high payload bit and always takes *step* to `ST_PAYLO`. `ST_PAYLO` stores the low payload bit. It then takes *split-even* to `ST_PAREVEN` when the two payload bits hold an even number of ones, or *split-odd* to `ST_PARODD` otherwise. From either parity state the block takes *close* back to `ST_IDLE`. In `ST_PAREVEN` the result equals the line input, and in `ST_PARODD` it is the line input inverted. Each parity state therefore carries the parity of the payload, so the block needs no separate parity register. The result is a Mealy output: it depends on the state and on the line input in the same cycle.

Top module: `serial_frame_rx`

## Requirements
- R1: A synchronous active-high reset puts the machine in `ST_IDLE`, clears the payload register to 2'b00 and holds the result flag at 0.
- R2: In `ST_IDLE` a '0' on the line keeps the machine idle with no effect on the outputs. A '1' is taken as the first start bit.
- R3: If the bit after a first start bit is '0', the machine returns to idle (false start). The payload register is left untouched, and the next '1' begins a new frame.
- R4: After two '1' start bits, the next line bit is stored in payload bit 1 and the bit after it in payload bit 0.
- R5: In the parity-bit cycle the result flag is 1 exactly when the five frame bits hold an odd number of ones. It follows the line input within that same cycle.
- R6: The result flag is 0 in every cycle other than the parity-bit cycle.
- R7: After the parity-bit cycle the machine returns to idle whatever the check result. A '1' in the very next cycle starts a new frame.
- R8: The state vector holds exactly one set bit. Any state value that is not one of the six one-hot codes moves to `ST_IDLE` at the next clock.
- R9: The payload register keeps its last stored value through idle time, false starts and the parity cycle, until a new frame's payload bits replace it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Serial line input |
| parity_ok | output | 1 | Mealy result flag, valid only in the parity-bit cycle |
| payload | output | 2 | Last stored payload, bit 1 received first |

## Verification
The block has no parameters: the frame shape is fixed, so the bench builds the only variant there is. The bench sends all four payload values with correct and with wrong parity. It also sends false starts directly before real frames, frames back to back with no idle gap, long idle stretches, and a reset in the middle of a frame. Together these reach every transition of the six-state machine, both polarities of the Mealy flag and the hold behaviour of the payload register.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam int unsigned STATE_W = 6;
    localparam int unsigned PAY_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 6'b000001,
        ST_START2  = 6'b000010,
        ST_PAYHI   = 6'b000100,
        ST_PAYLO   = 6'b001000,
        ST_PAREVEN = 6'b010000,
        ST_PARODD  = 6'b100000
    } rx_state_e;

endpackage

// File: rtl/frame_rx_fsm.sv
module frame_rx_fsm
    import frame_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      hi_bit,
    output rx_state_e state,
    output logic      result,
    output logic      cap_hi,
    output logic      cap_lo
);

    rx_state_e state_q;
    rx_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:    state_d = din ? ST_START2 : ST_IDLE;
            ST_START2:  state_d = din ? ST_PAYHI  : ST_IDLE;
            ST_PAYHI:   state_d = ST_PAYLO;
            ST_PAYLO:   state_d = (hi_bit ^ din) ? ST_PARODD : ST_PAREVEN;
            ST_PAREVEN: state_d = ST_IDLE;
            ST_PARODD:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs (Mealy)
    always_comb begin
        result = 1'b0;
        cap_hi = 1'b0;
        cap_lo = 1'b0;
        unique case (state_q)
            ST_IDLE:    result = 1'b0;
            ST_START2:  result = 1'b0;
            ST_PAYHI:   cap_hi = 1'b1;
            ST_PAYLO:   cap_lo = 1'b1;
            ST_PAREVEN: result = din;
            ST_PARODD:  result = ~din;
            default:    result = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/frame_rx_payload.sv
module frame_rx_payload
    import frame_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             cap_hi,
    input  logic             cap_lo,
    output logic [PAY_W-1:0] data
);

    logic [PAY_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            if (cap_hi) data_q[PAY_W-1] <= din;
            if (cap_lo) data_q[0]       <= din;
        end
    end

    assign data = data_q;

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import frame_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       serial_in,
    output logic       parity_ok,
    output logic [1:0] payload
);

    rx_state_e        state_w;
    logic             cap_hi_w;
    logic             cap_lo_w;
    logic [PAY_W-1:0] data_w;

    frame_rx_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .din    (serial_in),
        .hi_bit (data_w[PAY_W-1]),
        .state  (state_w),
        .result (parity_ok),
        .cap_hi (cap_hi_w),
        .cap_lo (cap_lo_w)
    );

    frame_rx_payload u_pay (
        .clk    (clk),
        .rst    (rst),
        .din    (serial_in),
        .cap_hi (cap_hi_w),
        .cap_lo (cap_lo_w),
        .data   (data_w)
    );

    assign payload = data_w;

endmodule

// File: rtl/frame_rx_checker.sv
module frame_rx_checker
    import frame_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       ok,
    input logic [1:0] payload,
    input logic [5:0] state
);

    logic in_par;
    logic in_cap;
    assign in_par = (state == ST_PAREVEN) || (state == ST_PARODD);
    assign in_cap = (state == ST_PAYHI) || (state == ST_PAYLO);

    a_r8_onehot_state: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    a_r6_flag_only_in_parity: assert property (@(posedge clk) disable iff (rst)
        ok |-> in_par);

    a_r5_odd_total: assert property (@(posedge clk) disable iff (rst)
        in_par |-> (ok == (payload[1] ^ payload[0] ^ din)));

    a_r3_false_start_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START2 && !din) |=> (state == ST_IDLE));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !din) |=> (state == ST_IDLE));

    a_r4_high_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAYHI) |=> (payload[1] == $past(din)));

    a_r7_back_to_idle: assert property (@(posedge clk) disable iff (rst)
        in_par |=> (state == ST_IDLE));

    a_r9_payload_hold: assert property (@(posedge clk) disable iff (rst)
        !in_cap |=> $stable(payload));

endmodule

bind serial_frame_rx frame_rx_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (serial_in),
    .ok      (parity_ok),
    .payload (payload),
    .state   (state_w)
);

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       parity_ok;
    logic [1:0] payload;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    serial_frame_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .serial_in (din),
        .parity_ok (parity_ok),
        .payload   (payload)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one line bit, then check the Mealy flag within that same cycle
    task automatic tick(input bit b, input bit exp_ok, input string req);
        @(negedge clk);
        din = b;
        #1;
        check(parity_ok == exp_ok, req, int'(parity_ok), int'(exp_ok));
    endtask

    task automatic check_payload(input logic [1:0] exp, input string req);
        @(negedge clk);
        #1;
        check(payload == exp, req, int'(payload), int'(exp));
    endtask

    // Full frame: 1,1,d[1],d[0],p ; flag expected only on p
    task automatic send_frame(input logic [1:0] d, input bit p, input string req);
        bit odd;
        odd = 1'b1 ^ 1'b1 ^ d[1] ^ d[0] ^ p;
        tick(1'b1, 1'b0, "R6 start1");
        tick(1'b1, 1'b0, "R6 start2");
        tick(d[1], 1'b0, "R6 pay_hi");
        tick(d[0], 1'b0, "R6 pay_lo");
        tick(p, odd, req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(parity_ok == 1'b0, "R1 flag in reset", int'(parity_ok), 0);
        check(payload == 2'b00, "R1 payload in reset", int'(payload), 0);
        @(negedge clk);
        din = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_good_frames();
        for (int v = 0; v < 4; v++) begin
            logic [1:0] d;
            d = 2'(v);
            send_frame(d, ~(d[1] ^ d[0]), "R5 good parity");
            tick(1'b0, 1'b0, "R7 idle after frame");
            check(payload == d, "R4 payload msb first", int'(payload), int'(d));
        end
    endtask

    task automatic t_bad_frames();
        for (int v = 0; v < 4; v++) begin
            logic [1:0] d;
            d = 2'(v);
            send_frame(d, d[1] ^ d[0], "R5 bad parity");
            tick(1'b0, 1'b0, "R6 idle after bad");
            check(payload == d, "R4 payload on bad parity", int'(payload), int'(d));
        end
    endtask

    task automatic t_idle_zeros();
        logic [1:0] held;
        held = payload;
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b0, "R2 idle zeros");
        check(payload == held, "R9 hold in idle", int'(payload), int'(held));
    endtask

    task automatic t_false_start();
        send_frame(2'b10, 1'b0, "R5 setup frame");
        tick(1'b0, 1'b0, "R6 gap");
        tick(1'b1, 1'b0, "R3 lone one");
        tick(1'b0, 1'b0, "R3 reject");
        check_payload(2'b10, "R9 hold after false start");
        // false start immediately followed by a real frame
        tick(1'b1, 1'b0, "R3 lone one b");
        tick(1'b0, 1'b0, "R3 reject b");
        send_frame(2'b01, 1'b1, "R3 frame after false start");
        tick(1'b0, 1'b0, "R6 gap");
        check(payload == 2'b01, "R3 payload after false start", int'(payload), 1);
    endtask

    task automatic t_back_to_back();
        send_frame(2'b11, 1'b1, "R7 first frame");
        send_frame(2'b00, 1'b1, "R7 second frame");
        send_frame(2'b10, 1'b0, "R7 third frame");
        tick(1'b0, 1'b0, "R6 gap");
        check(payload == 2'b10, "R7 payload after back to back", int'(payload), 2);
    endtask

    task automatic t_reset_mid_frame();
        send_frame(2'b11, 1'b1, "R5 pre-reset frame");
        tick(1'b1, 1'b0, "R6 s1");
        tick(1'b1, 1'b0, "R6 s2");
        tick(1'b1, 1'b0, "R6 hi");
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        din = 1'b0;
        #1;
        check(payload == 2'b00, "R1 payload cleared mid frame", int'(payload), 0);
        tick(1'b1, 1'b0, "R1 idle after reset s1");
        tick(1'b1, 1'b0, "R1 idle after reset s2");
        tick(1'b0, 1'b0, "R6 hi");
        tick(1'b1, 1'b0, "R6 lo");
        tick(1'b0, 1'b1, "R5 frame after reset");
        tick(1'b0, 1'b0, "R6 gap");
        check(payload == 2'b01, "R4 payload after reset", int'(payload), 1);
    endtask

    initial begin
        // R8: one-hot legality is covered by the bound checker
        t_reset();
        t_good_frames();
        t_bad_frames();
        t_idle_zeros();
        t_false_start();
        t_back_to_back();
        t_reset_mid_frame();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule